// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-pin general-purpose I/O peripheral reached through a simple word-wide register bus (address, write strobe, write data, read strobe, read data). Software programs each pin as an input or an output, may select open-drain signalling for output pins, and drives or samples pin values through a data register. The pad interface exposes a per-pin output value and output enable, so an external tristate buffer forms the physical pin.

Each pad input is brought into the clock domain by a two-flop synchroniser and compared with its value one cycle earlier. A detected edge sets a sticky event bit. Software clears event bits by writing ones. A per-pin control bit chooses between falling-edge-only detection and detection of both edges. A single registered interrupt line is raised while any event bit is also enabled in the mask register.

Register bits follow a reversed numbering: pin n lives in register bit 31 − n. Pad ports use plain pin numbering, with bit n meaning pin n.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers are decoded at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 edge control. Direction, open-drain, mask and edge control read back what was written. A read returns its value on `rdata_o` after the clock edge that samples `rd_en_i`, and `rdata_o` holds it until the next read. Offsets not listed, or with address bits [1:0] not zero, read as 0, and writes to them change nothing.
- R2: Pin n is held in register bit 31 − n in every register, and pad port bit n is pin n.
- R3: A direction bit of 1 makes the pin an output, and 0 makes it an input. An input pin never has its output enable asserted. A push-pull output pin has its output enable at 1 and drives the data register bit.
- R4: An output pin whose open-drain bit is 1 drives 0 with output enable at 1 when its data bit is 0. It releases the pad (output enable 0) when its data bit is 1, and it never drives a 1.
- R5: A read of the data register returns the driven data bit for output pins and the synchronised pad level for input pins.
- R6: With edge control 0, both rising and falling pad edges set the pin's event bit, whatever the mask holds.
- R7: With edge control 1, only a falling pad edge sets the pin's event bit. A rising edge leaves it unchanged.
- R8: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. An edge detected in the same cycle as a clear of that bit leaves the bit set.
- R9: `irq_o` is a registered copy of the OR over all pins of (event AND mask). A mask bit of 1 enables the pin.
- R10: Reset clears every register, so all pins are unmasked-off inputs with no output enable, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| pad_in_i | input | 32 | Pad input levels, bit n is pin n |
| pad_out_o | output | 32 | Pad output values, bit n is pin n |
| pad_oe_o | output | 32 | Pad output enables, bit n is pin n |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted event register shows up on `irq_o` one cycle after the bad bit meets an enabled mask. It shows on `rdata_o` at the next event-register read, so each edge test reads events back directly instead of trusting the interrupt line. A wrong direction or open-drain state reaches `pad_oe_o` and `pad_out_o` in the same cycle as the register update. A broken synchroniser or edge comparator moves or drops events; the same-cycle set-versus-clear test depends on the exact two-stage latency and exposes any change in it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    SEL_DIR = 3'd0,
    SEL_OD  = 3'd1,
    SEL_DAT = 3'd2,
    SEL_EVT = 3'd3,
    SEL_MSK = 3'd4,
    SEL_CTL = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] fall_only_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    // any change; in falling-only mode the old level must have been high
    assign hit_o[i] = (lvl_i[i] ^ prev_q[i]) & (~fall_only_i[i] | prev_q[i]);
  end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int W = 32
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] od_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o
);
  // register bit b serves pin W-1-b
  for (genvar p = 0; p < W; p++) begin : g_pin
    localparam int B = W - 1 - p;
    assign out_o[p] = od_i[B] ? 1'b0 : dat_i[B];
    assign oe_o[p]  = dir_i[B] & (od_i[B] ? ~dat_i[B] : 1'b1);
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [N_PINS-1:0] dir_q, od_q, dat_q, evt_q, mask_q, ctl_q;
  logic [N_PINS-1:0] pad_in_r, lvl_r, hit_r, evt_clr, rd_mux, rdata_q;
  logic              irq_q, aligned;
  logic [WORD_W-1:0] word;

  for (genvar p = 0; p < N_PINS; p++) begin : g_in_rev
    assign pad_in_r[N_PINS-1-p] = pad_in_i[p];
  end

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_r),
    .sync_o  (lvl_r)
  );

  gpio_edge_det #(.W(N_PINS)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (lvl_r),
    .fall_only_i (ctl_q),
    .hit_o       (hit_r)
  );

  gpio_pad_drv #(.W(N_PINS)) u_pad (
    .dir_i (dir_q),
    .od_i  (od_q),
    .dat_i (dat_q),
    .out_o (pad_out_o),
    .oe_o  (pad_oe_o)
  );

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];

  function automatic logic hits(input logic [WORD_W-1:0] w, input reg_sel_e s);
    return w == WORD_W'(s);
  endfunction

  logic wr_ok;
  assign wr_ok   = wr_en_i & aligned;
  assign evt_clr = (wr_ok && hits(word, SEL_EVT)) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      od_q   <= '0;
      dat_q  <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
    end else if (wr_ok) begin
      if (hits(word, SEL_DIR)) dir_q  <= wdata_i;
      if (hits(word, SEL_OD))  od_q   <= wdata_i;
      if (hits(word, SEL_DAT)) dat_q  <= wdata_i;
      if (hits(word, SEL_MSK)) mask_q <= wdata_i;
      if (hits(word, SEL_CTL)) ctl_q  <= wdata_i;
    end
  end

  // new edges take priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~evt_clr) | hit_r;
      irq_q <= |(evt_q & mask_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (hits(word, SEL_DIR)) rd_mux = dir_q;
      if (hits(word, SEL_OD))  rd_mux = od_q;
      if (hits(word, SEL_DAT)) rd_mux = (dir_q & dat_q) | (~dir_q & lvl_r);
      if (hits(word, SEL_EVT)) rd_mux = evt_q;
      if (hits(word, SEL_MSK)) rd_mux = mask_q;
      if (hits(word, SEL_CTL)) rd_mux = ctl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_PINS-1:0] evt_q,
  input logic [N_PINS-1:0] mask_q,
  input logic [N_PINS-1:0] dir_q,
  input logic [N_PINS-1:0] od_q,
  input logic [N_PINS-1:0] pad_out_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              irq_o
);
  logic [N_PINS-1:0] dir_pin, od_pin;
  logic              evt_wr;

  for (genvar p = 0; p < N_PINS; p++) begin : g_rev
    assign dir_pin[p] = dir_q[N_PINS-1-p];
    assign od_pin[p]  = od_q[N_PINS-1-p];
  end

  assign evt_wr = wr_en_i && (addr_i == ADDR_W'(12));

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R8

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o); // R9

  AST_OE_ONLY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_pin) == '0); // R3

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_out_o & od_pin) == '0); // R4
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .evt_q     (evt_q),
  .mask_q    (mask_q),
  .dir_q     (dir_q),
  .od_q      (od_q),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .irq_o     (irq_o)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] pad_in_i = '0;
  logic [31:0] pad_out_o;
  logic [31:0] pad_oe_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_edge_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // R1 register map and address decode
  localparam vec_t VECS [7] = '{
    '{5'h00, 32'h1234_5678, 5'h00, 32'h1234_5678},
    '{5'h04, 32'h0F0F_0000, 5'h04, 32'h0F0F_0000},
    '{5'h10, 32'h0000_00A5, 5'h10, 32'h0000_00A5},
    '{5'h14, 32'hDEAD_BEEF, 5'h14, 32'hDEAD_BEEF},
    '{5'h18, 32'hFFFF_FFFF, 5'h18, 32'h0000_0000},
    '{5'h01, 32'hFFFF_FFFF, 5'h00, 32'h1234_5678},
    '{5'h1C, 32'hFFFF_FFFF, 5'h14, 32'hDEAD_BEEF}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R10 reset state
    check("R10 irq", {31'b0, irq_o}, 32'h0);
    check("R10 oe", pad_oe_o, 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), v);
      check("R10 reg", v, 32'h0);
    end

    for (int i = 0; i < 7; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, v);
      check("R1 vector", v, VECS[i].ex);
    end
    wr(5'h00, 0); wr(5'h04, 0); wr(5'h10, 0); wr(5'h14, 0);

    // R2 R3 pins 0 and 31 as push-pull outputs
    wr(5'h00, 32'h8000_0001);
    wr(5'h08, 32'h8000_0000);
    idle(1);
    check("R2 R3 oe", pad_oe_o, 32'h8000_0001);
    check("R2 R3 out", pad_out_o, 32'h0000_0001);

    // R4 open drain
    wr(5'h04, 32'h8000_0001);
    idle(1);
    check("R4 oe", pad_oe_o, 32'h8000_0000);
    check("R4 out", pad_out_o, 32'h0);
    wr(5'h04, 0);

    // R5 mixed read of data register
    wr(5'h08, 32'hFFFF_FFFF);
    pad_in_i = 32'h0000_0002;
    idle(4);
    rd(5'h08, v);
    check("R5 data read", v, 32'hC000_0001);
    pad_in_i = '0;
    wr(5'h00, 0);
    idle(4);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v);
    check("R8 clear all", v, 32'h0);

    // R6 both edges, mask off
    pad_in_i[4] = 1'b1;
    idle(4);
    rd(5'h0C, v);
    check("R6 rise", v, 32'h0800_0000);
    check("R6 irq masked", {31'b0, irq_o}, 32'h0);
    wr(5'h0C, 32'h0000_0000);
    rd(5'h0C, v);
    check("R8 write zero", v, 32'h0800_0000);
    wr(5'h0C, 32'h0800_0000);
    pad_in_i[4] = 1'b0;
    idle(4);
    rd(5'h0C, v);
    check("R6 fall", v, 32'h0800_0000);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R7 falling-only on pin 5
    wr(5'h14, 32'h0400_0000);
    pad_in_i[5] = 1'b1;
    idle(4);
    rd(5'h0C, v);
    check("R7 rise ignored", v, 32'h0);
    pad_in_i[5] = 1'b0;
    idle(4);
    rd(5'h0C, v);
    check("R7 fall", v, 32'h0400_0000);

    // R9 interrupt
    wr(5'h10, 32'h0800_0000);
    idle(3);
    check("R9 other mask", {31'b0, irq_o}, 32'h0);
    wr(5'h10, 32'h0400_0000);
    idle(2);
    check("R9 irq set", {31'b0, irq_o}, 32'h1);
    wr(5'h0C, 32'h0400_0000);
    idle(2);
    check("R9 irq cleared", {31'b0, irq_o}, 32'h0);
    wr(5'h10, 0);
    wr(5'h14, 0);

    // R8 edge and clear in same cycle: set wins
    @(negedge clk_i);
    pad_in_i[4] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    addr_i = 5'h0C; wdata_i = 32'h0800_0000; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    idle(2);
    rd(5'h0C, v);
    check("R8 set wins", v, 32'h0800_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule